// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block recovers characters from a single idle-high serial line that has no clock. Each frame starts with a low start bit. The data bits follow least significant bit first, then an optional ninth bit, then a high stop bit. An external rate generator supplies a one-cycle `tick` pulse at sixteen times the bit rate. Every bit is judged at its centre by a two-of-three vote over three consecutive ticks.

Received characters are queued in a two-entry buffer. Each entry holds the data byte, its ninth bit and a flag that marks a missing stop bit. The consumer sees the oldest entry on the read outputs and removes it with a one-cycle `rd_pop` pulse.

When address filtering is switched on, the receiver always takes nine-bit frames and drops every frame whose ninth bit is clear. On a shared multidrop line, a node can therefore wait for an address frame without being flooded by data meant for other nodes. A third completed character that finds the buffer full raises a sticky overrun flag. While that flag is set, reception stops.

Top module: `serial_rx_addr`

## Requirements
- R1: After reset, `rd_valid` and `ovr_err` are 0 and `rx_idle` is 1.
- R2: With `nine_bit`=0, a frame is one low start bit, 8 data bits sent LSB first and a stop bit. The byte appears on `rd_data` with `rd_ninth`=0.
- R3: With `nine_bit`=1, a ninth bit sent after the 8 data bits and before the stop bit is stored with its character and appears on `rd_ninth`.
- R4: A stop bit sampled low sets `rd_ferr`=1 for that character. The character is still stored with its data intact. A good stop bit gives `rd_ferr`=0.
- R5: The buffer holds two characters in arrival order, and `rd_valid` is 1 while it is non-empty. A `rd_pop` pulse removes the oldest entry. A pop while the buffer is empty has no effect.
- R6: A character that completes while two entries are held sets `ovr_err` and is dropped. While `ovr_err` is 1, no further character is stored. Driving `cont_rx` low clears `ovr_err` on the next cycle.
- R7: With `addr_det`=1, frames are taken as nine-bit frames whatever `nine_bit` is. A frame whose ninth bit is 0 never enters the buffer. A frame whose ninth bit is 1 is stored.
- R8: Each bit value is the majority of three consecutive tick samples at mid-bit, so a line glitch of one tick or less at mid-bit does not change the received data.
- R9: A low level on an idle line that ends before mid-bit is rejected as a false start. No character is stored and `rx_idle` returns to 1.
- R10: `rx_idle` is 0 while a frame is being assembled and 1 otherwise.
- R11: With `en`=0, the receiver stays idle and the buffer and `ovr_err` are cleared by the next cycle. With `cont_rx`=0, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears the buffer and the receiver |
| nine_bit | input | 1 | Nine-bit frame mode |
| addr_det | input | 1 | Address filter: keep only frames whose ninth bit is 1 |
| cont_rx | input | 1 | Receive enable; low also clears the overrun flag |
| tick | input | 1 | Sample strobe at OSR times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rd_pop | input | 1 | Remove the oldest buffered character |
| rd_data | output | DW | Data of the oldest character |
| rd_ninth | output | 1 | Ninth bit of the oldest character |
| rd_ferr | output | 1 | Framing flag of the oldest character |
| rd_valid | output | 1 | Buffer not empty |
| ovr_err | output | 1 | Overrun flag |
| rx_idle | output | 1 | No frame being assembled |

## Verification
The line passes through a two-flop synchronizer, so a frame finishes when the stop-bit vote is taken. That happens at tick 9 of the stop bit, about two cycles plus nine ticks after the stop bit begins on `rxd`. The bench holds every frame's stop bit for a full bit and then adds one idle bit time before it reads the buffer, so the stored character has settled well before it is sampled. Pops and the `cont_rx` and `en` controls take effect on the next clock edge, and those results are checked at the following falling edge. All 256 byte values are swept through 8-bit mode. Both ninth-bit values, framing errors, overrun, glitches and false starts are then checked with expected values computed in the bench.

// File: rtl/serial_rx_addr.sv
module serial_rx_addr #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          nine_bit,
  input  logic          addr_det,
  input  logic          cont_rx,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_ninth,
  output logic          rd_ferr,
  output logic          rd_valid,
  output logic          ovr_err,
  output logic          rx_idle
);
  localparam int PW  = $clog2(OSR);
  localparam int BW  = $clog2(DW + 3);
  localparam int MID = OSR / 2;
  localparam int EW  = DW + 2;

  logic [1:0]    sync;
  logic          rx_s;
  logic          busy;
  logic [PW-1:0] ph;
  logic [BW-1:0] bi;
  logic          s0, s1;
  logic [DW:0]   sh;
  logic [EW-1:0] mem [2];
  logic          wp, rp;
  logic [1:0]    cnt;

  wire           nine   = nine_bit | addr_det;
  wire  [BW-1:0] nb     = nine ? BW'(DW + 1) : BW'(DW);
  wire           active = en & cont_rx & ~ovr_err;
  wire           vote   = (s0 & s1) | (s0 & rx_s) | (s1 & rx_s);
  wire           decide = busy & tick & (ph == PW'(MID + 1));
  wire           fin    = decide & (bi > nb);
  wire  [DW-1:0] f_data = nine ? sh[DW-1:0] : sh[DW:1];
  wire           f_nine = nine & sh[DW];
  wire           keep   = fin & ~(addr_det & ~f_nine);
  wire           full   = (cnt == 2'd2);
  wire           push   = keep & ~full;
  wire           pop    = rd_pop & (cnt != 2'd0);

  assign rx_s     = sync[1];
  assign rx_idle  = ~busy;
  assign rd_valid = (cnt != 2'd0);
  assign {rd_ferr, rd_ninth, rd_data} = mem[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
      bi   <= '0;
      s0   <= 1'b1;
      s1   <= 1'b1;
      sh   <= '0;
    end else if (!active) begin
      busy <= 1'b0;
    end else if (tick) begin
      if (!busy) begin
        if (!rx_s) begin
          busy <= 1'b1;
          ph   <= PW'(1);
          bi   <= '0;
        end
      end else begin
        ph <= (ph == PW'(OSR - 1)) ? '0 : ph + 1'b1;
        if (ph == PW'(OSR - 1)) bi <= bi + 1'b1;
        if (ph == PW'(MID - 1)) s0 <= rx_s;
        if (ph == PW'(MID))     s1 <= rx_s;
        if (decide) begin
          if (bi == '0) begin
            if (vote) busy <= 1'b0;
          end else if (bi <= nb) begin
            sh <= {vote, sh[DW:1]};
          end else begin
            busy <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= 1'b0;
      rp      <= 1'b0;
      cnt     <= 2'd0;
      ovr_err <= 1'b0;
      mem[0]  <= '0;
      mem[1]  <= '0;
    end else if (!en) begin
      wp      <= 1'b0;
      rp      <= 1'b0;
      cnt     <= 2'd0;
      ovr_err <= 1'b0;
    end else begin
      if (!cont_rx)         ovr_err <= 1'b0;
      else if (keep & full) ovr_err <= 1'b1;
      if (push) begin
        mem[wp] <= {~vote, f_nine, f_data};
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
    end
  end
endmodule

// File: rtl/serial_rx_addr_chk.sv
module serial_rx_addr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cont_rx,
  input logic       rd_pop,
  input logic       rd_valid,
  input logic       ovr_err,
  input logic       rx_idle,
  input logic [1:0] cnt
);
  p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  p_empty_only_by_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> ($past(rd_pop) || !$past(en)));

  p_ovr_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> ($past(cnt) == 2'd2));

  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_rx || !en) |=> !ovr_err);

  p_no_store_in_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && en && !rd_pop) |=> (cnt == $past(cnt)));

  p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_idle && !rd_valid));
endmodule

bind serial_rx_addr serial_rx_addr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cont_rx(cont_rx), .rd_pop(rd_pop),
  .rd_valid(rd_valid), .ovr_err(ovr_err), .rx_idle(rx_idle), .cnt(cnt)
);

// File: tb/sim_serial_rx_addr.sv
`timescale 1ns/1ps
module sim_serial_rx_addr;
  localparam int BIT = 32;

  logic clk = 0, rst_n = 0, en = 1, nine_bit = 0, addr_det = 0, cont_rx = 1;
  logic tick = 0, rxd = 1, rd_pop = 0;
  logic [7:0] rd_data;
  logic rd_ninth, rd_ferr, rd_valid, ovr_err, rx_idle;
  int ncomp = 0, nfail = 0;
  logic idle_mid;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  serial_rx_addr u0 (.clk(clk), .rst_n(rst_n), .en(en), .nine_bit(nine_bit),
    .addr_det(addr_det), .cont_rx(cont_rx), .tick(tick), .rxd(rxd),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_ninth(rd_ninth), .rd_ferr(rd_ferr),
    .rd_valid(rd_valid), .ovr_err(ovr_err), .rx_idle(rx_idle));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncomp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] v, input bit nine, input bit stopb, input int gbit);
    @(negedge clk) rxd = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd = v[i];
      for (int c = 0; c < BIT; c++) begin
        @(negedge clk);
        if (i == 3 && c == BIT / 2) idle_mid = rx_idle;
        if (i == gbit) rxd = (c == BIT / 2 - 1) ? ~v[i] : v[i];
      end
    end
    rxd = stopb;
    repeat (BIT) @(negedge clk);
    rxd = 1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic pop();
    rd_pop = 1;
    @(negedge clk) rd_pop = 0;
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 ovr_err", ovr_err, 0);
    chk("R1 rx_idle", rx_idle, 1);

    for (int b = 0; b < 256; b++) begin
      send({1'b0, 8'(b)}, 0, 1, -1);
      chk("R2 valid", rd_valid, 1);
      chk("R2 data", rd_data, b);
      chk("R2 ninth", rd_ninth, 0);
      chk("R4 ferr clear", rd_ferr, 0);
      pop();
    end
    chk("R10 busy mid-frame", idle_mid, 0);
    chk("R10 idle after", rx_idle, 1);

    nine_bit = 1;
    for (int k = 0; k < 16; k++) begin
      logic [8:0] v = {k[0], 8'(k * 37 + 5)};
      send(v, 1, 1, -1);
      chk("R3 data", rd_data, v[7:0]);
      chk("R3 ninth", rd_ninth, v[8]);
      pop();
    end
    nine_bit = 0;

    send(9'h0A5, 0, 0, -1);
    chk("R4 ferr set", rd_ferr, 1);
    chk("R4 data kept", rd_data, 8'hA5);
    pop();
    repeat (3 * BIT) @(negedge clk);
    chk("R9 after ferr", rd_valid, 0);

    send(9'h03C, 0, 1, 2);
    chk("R8 glitch data", rd_data, 8'h3C);
    pop();
    send(9'h0C3, 0, 1, 6);
    chk("R8 glitch data", rd_data, 8'hC3);
    pop();

    rxd = 0;
    repeat (6) @(negedge clk);
    rxd = 1;
    repeat (3 * BIT) @(negedge clk);
    chk("R9 no char", rd_valid, 0);
    chk("R9 idle", rx_idle, 1);

    pop();
    chk("R5 pop empty", rd_valid, 0);

    send(9'h011, 0, 1, -1);
    send(9'h022, 0, 1, -1);
    chk("R6 no ovr at two", ovr_err, 0);
    send(9'h033, 0, 1, -1);
    chk("R6 ovr set", ovr_err, 1);
    send(9'h044, 0, 1, -1);
    chk("R5 order first", rd_data, 8'h11);
    pop();
    chk("R5 order second", rd_data, 8'h22);
    pop();
    chk("R6 dropped", rd_valid, 0);
    send(9'h055, 0, 1, -1);
    chk("R6 blocked while ovr", rd_valid, 0);
    cont_rx = 0;
    @(negedge clk);
    chk("R6 ovr cleared", ovr_err, 0);
    send(9'h066, 0, 1, -1);
    chk("R11 cont_rx off", rd_valid, 0);
    cont_rx = 1;
    @(negedge clk);

    addr_det = 1;
    send(9'h07E, 1, 1, -1);
    chk("R7 drop ninth0", rd_valid, 0);
    send(9'h17E, 1, 1, -1);
    chk("R7 keep ninth1", rd_valid, 1);
    chk("R7 data", rd_data, 8'h7E);
    chk("R7 ninth", rd_ninth, 1);
    pop();
    addr_det = 0;

    send(9'h099, 0, 1, -1);
    en = 0;
    @(negedge clk);
    chk("R11 flush", rd_valid, 0);
    chk("R11 idle", rx_idle, 1);
    en = 1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
    $finish;
  end
endmodule